// File: doc/BRIEF.md
# Prioritized Exception Cause Selector

This unit condenses a 16-flag exception vector into one cause code. It first clears every flag the selected mask does not allow. It then picks the single surviving flag that ranks highest in a fixed priority list. The list is deliberately not in cause-number order: a breakpoint outranks everything, and among the memory causes the store faults rank above the matching load faults.

The block is purely combinational and has no clock or reset. Its outputs follow its inputs within the same cycle, so a pipeline stage that collects exception flags can place it directly in front of its commit or trap logic. A two-bit select chooses one of four masks: every defined cause, only the causes a fetch front end can raise, a per-instance mask set by a parameter, or none at all. The masked vector is also driven out so that neighbouring logic can see which flags survived.

Top module: `exc_cause_sel`

## Requirements
- R1: With `mask_sel` = 0 (full set), `masked_out` equals `flags_in` with bits 10 and 14 forced to zero. Every other position passes through.
- R2: With `mask_sel` = 1 (front-end set), `masked_out` keeps only bits 0, 1, 2 and 12 of `flags_in`. All other bits are zero.
- R3: With `mask_sel` = 2 (unit set), `masked_out` equals `flags_in & UNIT_MASK`, with bits 10 and 14 still forced to zero. The default `UNIT_MASK` is 16'hA0F0, which selects bits 4 to 7, 13 and 15.
- R4: With `mask_sel` = 3 (no causes), `masked_out` is zero and `valid` is low, whatever `flags_in` holds.
- R5: `valid` is high exactly when at least one bit of `masked_out` is set.
- R6: When `valid` is low, `cause` is 4'd0.
- R7: When `valid` is high, `cause` is the number of the set bit in `masked_out` that comes first in this list, highest priority first: 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5.
- R8: If bit 3 (breakpoint) survives the mask, `cause` is 3 regardless of any other flags. A store cause (6, 15, 7) beats the load cause of the same kind (4, 13, 5).
- R9: The outputs are combinational: they settle within the same cycle as any change of `flags_in` or `mask_sel`, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flags_in | input | 16 | Raw exception flags, one bit per cause number |
| mask_sel | input | 2 | Mask choice: 0 full, 1 front-end, 2 unit parameter, 3 none |
| masked_out | output | 16 | Flags that survive the selected mask |
| valid | output | 1 | At least one cause survived |
| cause | output | 4 | Number of the winning cause, zero when none survived |

## Verification
The bench tries every single-hot input under each mask. This catches a mask that lets a wrong bit through or drops a kept one, and it catches the reserved positions 10 and 14 leaking into the full or unit set. Random multi-hot vectors are checked against a reference model that walks the priority list. A picker that ranked by cause number would then return 15 instead of 3, or 7 instead of 6. Directed cases put a breakpoint beside every other flag, pit each store fault against its load counterpart, and feed an all-ones vector to every mask. A design whose `cause` kept a stale or nonzero code while `valid` was low would also fail these cases.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

    localparam int VEC_W   = 16;
    localparam int CODE_W  = $clog2(VEC_W);
    localparam int NUM_RANK = 14;

    // Mask choice presented on mask_sel
    typedef enum logic [1:0] {
        SEL_ALL   = 2'd0,
        SEL_FRONT = 2'd1,
        SEL_UNIT  = 2'd2,
        SEL_NONE  = 2'd3
    } mask_sel_e;

    // Every defined cause; positions 10 and 14 are reserved
    localparam logic [VEC_W-1:0] FULL_SET  = 16'hBBFF;
    // Causes a fetch front end can raise: 0, 1, 2, 12
    localparam logic [VEC_W-1:0] FRONT_SET = 16'h1007;

    // Ranked cause numbers, index 0 wins
    localparam logic [CODE_W-1:0] RANK_LIST [NUM_RANK] = '{
        4'd3, 4'd12, 4'd1, 4'd2, 4'd0, 4'd11, 4'd9,
        4'd8, 4'd6,  4'd4, 4'd15, 4'd13, 4'd7, 4'd5
    };

endpackage

// File: rtl/exc_mask_unit.sv
module exc_mask_unit
    import exc_sel_pkg::*;
#(
    parameter logic [VEC_W-1:0] UNIT_MASK = 16'hA0F0
) (
    input  logic [VEC_W-1:0] raw_flags,
    input  mask_sel_e        sel,
    output logic [VEC_W-1:0] kept_flags
);

    localparam logic [VEC_W-1:0] UNIT_SET = UNIT_MASK & FULL_SET;

    logic [VEC_W-1:0] keep_mask;

    always_comb begin
        unique case (sel)
            SEL_ALL:   keep_mask = FULL_SET;
            SEL_FRONT: keep_mask = FRONT_SET;
            SEL_UNIT:  keep_mask = UNIT_SET;
            SEL_NONE:  keep_mask = '0;
            default:   keep_mask = '0;
        endcase
    end

    assign kept_flags = raw_flags & keep_mask;

    always_comb begin
        // R1: the reserved positions never survive
        p_reserved_clear_r1: assert (kept_flags[10] == 1'b0 && kept_flags[14] == 1'b0);
        // R2: front-end choice leaves nothing outside 0,1,2,12
        p_front_only_r2: assert (sel != SEL_FRONT || (kept_flags & ~16'h1007) == '0);
        // R4: the empty choice lets nothing through
        p_none_empty_r4: assert (sel != SEL_NONE || kept_flags == '0);
        // R1: a surviving flag was present on the input
        p_subset_r1: assert ((kept_flags & ~raw_flags) == '0);
    end

endmodule

// File: rtl/exc_rank_pick.sv
module exc_rank_pick
    import exc_sel_pkg::*;
(
    input  logic [VEC_W-1:0]  cand,
    output logic              hit,
    output logic [CODE_W-1:0] code
);

    // Walk from the lowest rank up so the highest rank is written last
    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int r = NUM_RANK - 1; r >= 0; r--) begin
            if (cand[RANK_LIST[r]]) begin
                hit  = 1'b1;
                code = RANK_LIST[r];
            end
        end
    end

    always_comb begin
        // R7: the chosen code points at a set candidate
        p_code_is_set_r7: assert (!hit || cand[code]);
        // R8: a surviving breakpoint always wins
        p_break_wins_r8: assert (!cand[3] || code == 4'd3);
    end

endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_sel_pkg::*;
#(
    parameter logic [15:0] UNIT_MASK = 16'hA0F0
) (
    input  logic [15:0] flags_in,
    input  logic [1:0]  mask_sel,
    output logic [15:0] masked_out,
    output logic        valid,
    output logic [3:0]  cause
);

    logic [VEC_W-1:0]  kept;
    logic              pick_hit;
    logic [CODE_W-1:0] pick_code;

    exc_mask_unit #(
        .UNIT_MASK (UNIT_MASK)
    ) u_mask (
        .raw_flags  (flags_in),
        .sel        (mask_sel_e'(mask_sel)),
        .kept_flags (kept)
    );

    exc_rank_pick u_pick (
        .cand (kept),
        .hit  (pick_hit),
        .code (pick_code)
    );

    assign masked_out = kept;
    assign valid      = pick_hit;
    assign cause      = pick_hit ? pick_code : '0;

    always_comb begin
        // R5: valid agrees with the vector the mask unit produced
        p_valid_matches_r5: assert (valid == (|masked_out));
        // R6: no stale code without a cause
        p_idle_zero_r6: assert (valid || cause == 4'd0);
    end

endmodule

// File: tb/exc_cause_sel_bench.sv
module exc_cause_sel_bench;

    logic        clk = 1'b0;
    logic [15:0] flags_in;
    logic [1:0]  mask_sel;
    logic [15:0] masked_out;
    logic        valid;
    logic [3:0]  cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    exc_cause_sel u_exc_cause_sel (
        .flags_in   (flags_in),
        .mask_sel   (mask_sel),
        .masked_out (masked_out),
        .valid      (valid),
        .cause      (cause)
    );

    function automatic logic [15:0] ref_mask(input logic [1:0] s);
        case (s)
            2'd0:    return 16'hFFFF & ~16'h4400;
            2'd1:    return 16'h1007;
            2'd2:    return 16'hA0F0;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [4:0] ref_pick(input logic [15:0] v);
        int order [14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};
        for (int i = 0; i < 14; i++)
            if (v[order[i]]) return {1'b1, 4'(order[i])};
        return 5'd0;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (flags %h sel %0d)", tag, got, exp, flags_in, mask_sel);
        end
    endtask

    task automatic apply(input logic [15:0] f, input logic [1:0] s, input string mtag);
        logic [15:0] em;
        logic [4:0]  ep;
        @(negedge clk);
        flags_in = f;
        mask_sel = s;
        #1;
        em = f & ref_mask(s);
        ep = ref_pick(em);
        check(mtag, masked_out, em);
        check("R5 valid", {15'd0, valid}, {15'd0, ep[4]});
        if (ep[4]) check("R7 cause", {12'd0, cause}, {12'd0, ep[3:0]});
        else       check("R6 idle cause", {12'd0, cause}, 16'd0);
    endtask

    function automatic string sel_tag(input logic [1:0] s);
        case (s)
            2'd0:    return "R1 full mask";
            2'd1:    return "R2 front mask";
            2'd2:    return "R3 unit mask";
            default: return "R4 none mask";
        endcase
    endfunction

    initial begin
        int seed_dummy;
        flags_in = '0;
        mask_sel = '0;
        seed_dummy = $urandom(32'd1234);
        #1;
        // R9: idle state with no flags, settled in the same cycle
        check("R9 idle valid", {15'd0, valid}, 16'd0);
        check("R9 idle masked", masked_out, 16'd0);

        for (int s = 0; s < 4; s++)
            for (int b = 0; b < 16; b++)
                apply(16'(1) << b, 2'(s), sel_tag(2'(s)));

        for (int s = 0; s < 4; s++)
            apply(16'hFFFF, 2'(s), sel_tag(2'(s)));

        // R8: breakpoint beside every other flag
        for (int b = 0; b < 16; b++) begin
            apply(16'h0008 | (16'(1) << b), 2'd0, "R8 break");
            check("R8 break wins", {12'd0, cause}, 16'd3);
        end
        // R8: store beats load of the same kind
        apply(16'h0050, 2'd0, "R8 pair");
        check("R8 misaligned", {12'd0, cause}, 16'd6);
        apply(16'hA000, 2'd0, "R8 pair");
        check("R8 page fault", {12'd0, cause}, 16'd15);
        apply(16'h00A0, 2'd2, "R8 pair");
        check("R8 access fault", {12'd0, cause}, 16'd7);
        // R4: full vector with nothing allowed
        apply(16'hFFFF, 2'd3, "R4 none mask");
        check("R4 no valid", {15'd0, valid}, 16'd0);

        for (int k = 0; k < 400; k++) begin
            logic [15:0] f;
            logic [1:0]  s;
            f = 16'($urandom);
            if (k % 3 == 0) f = f & 16'($urandom);
            s = 2'($urandom);
            apply(f, s, sel_tag(s));
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule